// File: doc/BRIEF.md
# CAN Transmit Buffer Flag Controller

This block keeps the status and control state of three CAN transmit message buffers. For each buffer it holds an empty flag, an interrupt enable, an abort request bit and an abort acknowledge bit. The CPU reaches this state through a small byte-wide register port. A write of 1 to a buffer's empty flag hands that buffer to the protocol engine for sending. The engine reports a finished send or a finished abort with one-cycle event pulses, and each pulse returns the buffer to the empty state.

The block turns this state into per-buffer transmission requests and per-buffer content-access blocks for the message storage, plus one transmit interrupt. An initialization-mode handshake freezes the empty flags at their reset value. A listen-only mode stops the CPU from scheduling buffers and suppresses all transmission requests. All pins are plain level or pulse control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `can_txbuf_flags`

## Requirements
- R1: After reset the empty flags read 3'b111, the interrupt enables, abort requests and abort acknowledges read 0, and bits 7:3 of every register read 0.
- R2: Register select encoding: 0 = empty flags, 1 = interrupt enables, 2 = abort requests, 3 = abort acknowledges (read-only). Bit i of each register belongs to buffer i. Read data follows the select combinationally, and bits 7:3 read 0.
- R3: Init mode is both init_req and init_ack at 1. While it is active, every empty flag is 1 on the following edge and every abort request is 0. CPU writes to the flag register take effect only when init_req and init_ack are both 0.
- R4: A flag-register write with bit i at 1 clears empty flag i on the next edge. A bit at 0 leaves its flag unchanged.
- R5: A sent or aborted event pulse for buffer i sets empty flag i on the next edge. If a CPU clear hits the same flag in the same cycle, the event wins.
- R6: An aborted event for buffer i sets abort acknowledge i. A clear that takes effect on empty flag i also clears acknowledge i. Any setting of empty flag i clears abort request i.
- R7: Writing 1 to abort request bit i sets it only while empty flag i is 0 and init mode is off. Writing 0 has no effect.
- R8: While listen_only is 1, CPU writes cannot clear any empty flag and no transmission request is driven.
- R9: tx_req[i] is 1 exactly when empty flag i is 0, listen_only is 0 and init mode is off.
- R10: buf_blocked[i] is 1 exactly when empty flag i is 0.
- R11: tx_irq is 1 exactly when some buffer has both its empty flag and its interrupt enable at 1.
- R12: The interrupt-enable register takes every write, in any mode, and reads back the written bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| listen_only | input | 1 | Listen-only mode |
| eng_sent | input | 3 | Per-buffer send-complete pulse from the engine |
| eng_aborted | input | 3 | Per-buffer abort-complete pulse from the engine |
| tx_req | output | 3 | Per-buffer transmission request |
| abort_pend | output | 3 | Per-buffer abort request to the engine |
| buf_blocked | output | 3 | Per-buffer content-access block |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench targets four cases. The first is a CPU clear and an engine event on the same flag in the same cycle: a design that lets the clear win would leave the buffer scheduled after its message has gone. The second is a flag write made while only one of the two init handshake signals is high: a design that tests only one of them would accept a write that must be dropped. The third is an abort request written while the buffer is already empty: a design that accepts it would leave a stale abort for the engine. The fourth is a clear and an abort-complete event in the same cycle: a design that gets this wrong would drop the abort acknowledge, or clear it after the buffer has gone back to empty.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;
  localparam int unsigned NBUF = 3;
  localparam int unsigned DW   = 8;
  typedef enum logic [1:0] {
    SEL_EMPTY = 2'd0,
    SEL_IEN   = 2'd1,
    SEL_ABREQ = 2'd2,
    SEL_ABACK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/can_txbuf_slot.sv
module can_txbuf_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic init_mode,
  input  logic clr_req,
  input  logic abort_wr,
  input  logic ien_wr,
  input  logic ien_val,
  input  logic sent_ev,
  input  logic aborted_ev,
  output logic empty,
  output logic ack,
  output logic abreq,
  output logic ien
);
  logic set_ev;
  logic clr_eff;
  logic empty_d, ack_d, abreq_d;

  assign set_ev  = sent_ev | aborted_ev;
  assign clr_eff = clr_req & ~set_ev & ~init_mode;

  always_comb begin
    empty_d = empty;
    if (init_mode || set_ev) empty_d = 1'b1;
    else if (clr_req)        empty_d = 1'b0;

    ack_d = ack;
    if (aborted_ev)   ack_d = 1'b1;
    else if (clr_eff) ack_d = 1'b0;

    abreq_d = abreq;
    if (init_mode || set_ev)    abreq_d = 1'b0;
    else if (abort_wr && !empty) abreq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty <= 1'b1;
      ack   <= 1'b0;
      abreq <= 1'b0;
      ien   <= 1'b0;
    end else begin
      empty <= empty_d;
      ack   <= ack_d;
      abreq <= abreq_d;
      if (ien_wr) ien <= ien_val;
    end
  end

  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> (empty && !abreq));
  // R5
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_ev || aborted_ev) |=> empty);
  // R6
  abort_ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted_ev |=> ack);
  // R6
  clear_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> !ack);
  // R6
  set_drops_abreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> !abreq);
  // R7
  abreq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abreq) |-> !empty);
endmodule

// File: rtl/can_txbuf_regif.sv
module can_txbuf_regif
  import can_txbuf_pkg::*;
#(
  parameter int unsigned N = NBUF,
  parameter int unsigned W = DW
) (
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic         init_req,
  input  logic         init_ack,
  input  logic         listen_only,
  input  logic [N-1:0] empty_v,
  input  logic [N-1:0] ien_v,
  input  logic [N-1:0] abreq_v,
  input  logic [N-1:0] ack_v,
  output logic [N-1:0] clr_req_v,
  output logic [N-1:0] abort_wr_v,
  output logic         ien_wr,
  output logic [W-1:0] reg_rdata
);
  localparam int unsigned PADW = W - N;
  reg_sel_e sel;
  logic     flag_wr_ok;
  logic     init_mode;
  logic [N-1:0] rd_sel;

  assign sel        = reg_sel_e'(reg_sel);
  assign init_mode  = init_req & init_ack;
  assign flag_wr_ok = reg_wr && (sel == SEL_EMPTY) && !init_req && !init_ack && !listen_only;
  assign clr_req_v  = flag_wr_ok ? reg_wdata[N-1:0] : '0;
  assign abort_wr_v = (reg_wr && (sel == SEL_ABREQ) && !init_mode) ? reg_wdata[N-1:0] : '0;
  assign ien_wr     = reg_wr && (sel == SEL_IEN);

  always_comb begin
    unique case (sel)
      SEL_EMPTY: rd_sel = empty_v;
      SEL_IEN:   rd_sel = ien_v;
      SEL_ABREQ: rd_sel = abreq_v;
      default:   rd_sel = ack_v;
    endcase
  end

  assign reg_rdata = {{PADW{1'b0}}, rd_sel};
endmodule

// File: rtl/can_txbuf_flags.sv
module can_txbuf_flags
  import can_txbuf_pkg::*;
#(
  parameter int unsigned N = NBUF,
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         init_req,
  input  logic         init_ack,
  input  logic         listen_only,
  input  logic [N-1:0] eng_sent,
  input  logic [N-1:0] eng_aborted,
  output logic [N-1:0] tx_req,
  output logic [N-1:0] abort_pend,
  output logic [N-1:0] buf_blocked,
  output logic         tx_irq
);
  logic         init_mode;
  logic         ien_wr;
  logic [N-1:0] empty_v, ien_v, abreq_v, ack_v;
  logic [N-1:0] clr_req_v, abort_wr_v;

  assign init_mode = init_req & init_ack;

  can_txbuf_regif #(.N(N), .W(W)) u_regif (
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .listen_only (listen_only),
    .empty_v     (empty_v),
    .ien_v       (ien_v),
    .abreq_v     (abreq_v),
    .ack_v       (ack_v),
    .clr_req_v   (clr_req_v),
    .abort_wr_v  (abort_wr_v),
    .ien_wr      (ien_wr),
    .reg_rdata   (reg_rdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    can_txbuf_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_mode  (init_mode),
      .clr_req    (clr_req_v[i]),
      .abort_wr   (abort_wr_v[i]),
      .ien_wr     (ien_wr),
      .ien_val    (reg_wdata[i]),
      .sent_ev    (eng_sent[i]),
      .aborted_ev (eng_aborted[i]),
      .empty      (empty_v[i]),
      .ack        (ack_v[i]),
      .abreq      (abreq_v[i]),
      .ien        (ien_v[i])
    );
  end

  assign tx_req      = (listen_only || init_mode) ? '0 : ~empty_v;
  assign abort_pend  = abreq_v;
  assign buf_blocked = ~empty_v;
  assign tx_irq      = |(empty_v & ien_v);

  // R8
  listen_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listen_only |=> (($past(buf_blocked) | ~buf_blocked) == '1));
  // R3
  partial_init_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req || init_ack) |=> (($past(buf_blocked) | ~buf_blocked) == '1));
  // R9
  req_only_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_req & ~buf_blocked) == '0));
endmodule

// File: tb/can_txbuf_flags_tb.sv
module can_txbuf_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       init_req = 1'b0, init_ack = 1'b0, listen_only = 1'b0;
  logic [2:0] eng_sent = 3'b0, eng_aborted = 3'b0;
  logic [2:0] tx_req, abort_pend, buf_blocked;
  logic       tx_irq;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_e, m_k, m_q, m_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txbuf_flags u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_req(init_req),
    .init_ack(init_ack), .listen_only(listen_only), .eng_sent(eng_sent),
    .eng_aborted(eng_aborted), .tx_req(tx_req), .abort_pend(abort_pend),
    .buf_blocked(buf_blocked), .tx_irq(tx_irq)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return {5'b0, m_e};
      2'd1: return {5'b0, m_n};
      2'd2: return {5'b0, m_q};
      default: return {5'b0, m_k};
    endcase
  endfunction

  function automatic logic [2:0] exp_tx();
    if (listen_only || (init_req && init_ack)) return 3'b0;
    return ~m_e;
  endfunction

  task automatic model_update();
    logic im, wok;
    logic [2:0] ne, nk, nq;
    im  = init_req & init_ack;
    wok = !init_req && !init_ack && !listen_only && reg_wr && reg_sel == 2'd0;
    for (int i = 0; i < 3; i++) begin
      logic sev, clr;
      sev = eng_sent[i] | eng_aborted[i];
      clr = wok && reg_wdata[i];
      ne[i] = (im || sev) ? 1'b1 : (clr ? 1'b0 : m_e[i]);
      nk[i] = eng_aborted[i] ? 1'b1 : ((clr && !sev && !im) ? 1'b0 : m_k[i]);
      nq[i] = (im || sev) ? 1'b0 :
              ((reg_wr && reg_sel == 2'd2 && reg_wdata[i] && !m_e[i]) ? 1'b1 : m_q[i]);
    end
    if (reg_wr && reg_sel == 2'd1) m_n = reg_wdata[2:0];
    m_e = ne; m_k = nk; m_q = nq;
  endtask

  // drive at negedge, check comb outputs, then commit on posedge
  task automatic step(bit wr, logic [1:0] s, logic [7:0] wd, logic [2:0] snt,
                      logic [2:0] abt, logic ir, logic ia, logic lo);
    @(negedge clk);
    reg_wr = wr; reg_sel = s; reg_wdata = wd; eng_sent = snt;
    eng_aborted = abt; init_req = ir; init_ack = ia; listen_only = lo;
    #1;
    chk("R2 rdata", reg_rdata, exp_rd(s));
    chk(lo ? "R8 tx_req" : "R9 tx_req", {5'b0, tx_req}, {5'b0, exp_tx()});
    chk("R10 buf_blocked", {5'b0, buf_blocked}, {5'b0, ~m_e});
    chk("R11 tx_irq", {7'b0, tx_irq}, {7'b0, |(m_e & m_n)});
    chk("R7 abort_pend", {5'b0, abort_pend}, {5'b0, m_q});
    @(posedge clk);
    model_update();
  endtask

  task automatic idle();
    step(0, 2'd0, 8'h00, 3'b0, 3'b0, 0, 0, 0);
  endtask

  task automatic rd(string tag, logic [1:0] s, logic [7:0] exp);
    @(negedge clk);
    reg_wr = 0; reg_sel = s; eng_sent = 0; eng_aborted = 0;
    init_req = 0; init_ack = 0; listen_only = 0;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5183));
    m_e = 3'b111; m_k = 0; m_q = 0; m_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd("R1 flags", 2'd0, 8'h07);
    rd("R1 ien",   2'd1, 8'h00);
    rd("R1 abreq", 2'd2, 8'h00);
    rd("R1 aback", 2'd3, 8'h00);
    // R4 write 0 ignored, write 1 clears
    step(1, 2'd0, 8'hF8, 0, 0, 0, 0, 0);
    rd("R4 zero ignored", 2'd0, 8'h07);
    step(1, 2'd0, 8'h05, 0, 0, 0, 0, 0);
    rd("R4 clear", 2'd0, 8'h02);
    // R7 abort request only on full buffer
    step(1, 2'd2, 8'h07, 0, 0, 0, 0, 0);
    rd("R7 abreq set", 2'd2, 8'h05);
    // R6 abort success sets ack and clears req, sets flag
    step(0, 2'd0, 8'h00, 0, 3'b001, 0, 0, 0);
    rd("R6 ack set", 2'd3, 8'h01);
    rd("R6 abreq dropped", 2'd2, 8'h04);
    // R6 clearing flag clears ack
    step(1, 2'd0, 8'h01, 0, 0, 0, 0, 0);
    rd("R6 ack cleared", 2'd3, 8'h00);
    // R5 clear and event same cycle: event wins
    step(1, 2'd0, 8'h02, 3'b010, 0, 0, 0, 0);
    rd("R5 set wins", 2'd0, 8'h02);
    // R6 clear plus abort event on same flag: ack set
    step(1, 2'd0, 8'h01, 0, 3'b001, 0, 0, 0);
    rd("R6 ack on race", 2'd3, 8'h01);
    // R8 listen blocks clearing
    step(1, 2'd0, 8'h07, 0, 0, 0, 0, 1);
    rd("R8 no clear", 2'd0, 8'h03);
    // R3 partial init blocks writes
    step(1, 2'd0, 8'h07, 0, 0, 1, 0, 0);
    rd("R3 partial init", 2'd0, 8'h03);
    // R3 full init forces flags to 1
    step(0, 2'd0, 8'h00, 0, 0, 1, 1, 0);
    rd("R3 init set", 2'd0, 8'h07);
    // R12 ien writes in any mode
    step(1, 2'd1, 8'hFD, 0, 0, 1, 1, 1);
    rd("R12 ien", 2'd1, 8'h05);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 2) != 0), 2'($urandom_range(0, 3)),
           8'($urandom()), ($urandom_range(0, 4) == 0) ? 3'($urandom()) : 3'b0,
           ($urandom_range(0, 6) == 0) ? 3'($urandom()) : 3'b0,
           (r == 0) || (r == 1), (r == 0) || (r == 2), (r >= 13));
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule